// File: doc/BRIEF.md
# Indirect Register Window Bridge

This block lets a 64-bit sideband register port reach a target register file through a small window instead of through a direct mapping. Software first writes a target offset into the offset register. It then reads or writes the window register, and the bridge carries out one 8-byte access on the target port at the offset it latched. The bridge also holds a flag register that records protocol errors. Software clears a flag by writing a one to its bit.

Two further sideband indices act as sinks. Writes to them are accepted with no error and change nothing. A write to any other unassigned index is refused with an error flag. Every sideband access must carry a byte count of 8. The register index is the byte address shifted right by three, so the three low address bits play no part in decoding. A target access is a request/acknowledge handshake, and the sideband response for a window access is held back until the target acknowledges.

Top module: `idxb_top`

## Requirements
- R1: After reset the offset and flag registers read zero, and `tgt_req`, `sb_done` and `sb_busy` are low.
- R2: A write to index 0 (offset register) stores only the low 12 bits of the written data. A read of index 0 returns that offset zero-extended to 64 bits.
- R3: A read of index 1 (window) issues one target read at the stored offset. The sideband response carries the target's data.
- R4: A write to index 1 issues one target write at the stored offset with the written data, and the response returns zero data.
- R5: A write to index 2 (flag register, bit 0 = unassigned-index write, bit 1 = bad byte count) clears every flag bit that is one in the written data and leaves the other bits as they were.
- R6: Writes to indices 5 and 6 complete with no error, reach no target access and leave the offset and flag registers unchanged. Reads of them return zero.
- R7: A write to any index other than 0, 1, 2, 5 and 6 completes with `sb_err` high and sets flag bit 0. It has no other effect.
- R8: An access whose `sb_size` is not 8 completes with `sb_err` high and sets flag bit 1. It makes no target access and changes no register.
- R9: The register index is `sb_addr >> 3`. Address bits [2:0] do not affect decoding.
- R10: While a target access is outstanding, `tgt_req` stays high with `tgt_off`, `tgt_we` and `tgt_wdata` stable, and `sb_busy` is high. `sb_done` pulses in the cycle after the acknowledge.
- R11: A read of an unassigned index returns zero with no error and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_req | input | 1 | Sideband access request, taken when `sb_busy` is low |
| sb_we | input | 1 | 1 = write, 0 = read |
| sb_addr | input | 16 | Sideband byte address |
| sb_size | input | 4 | Access byte count, only 8 is legal |
| sb_wdata | input | 64 | Sideband write data |
| sb_busy | output | 1 | A window access is in flight |
| sb_done | output | 1 | One-cycle response strobe |
| sb_rdata | output | 64 | Response data, valid with `sb_done` |
| sb_err | output | 1 | Response error, valid with `sb_done` |
| tgt_req | output | 1 | Target access request |
| tgt_we | output | 1 | Target write enable |
| tgt_off | output | 12 | Target register offset |
| tgt_wdata | output | 64 | Target write data |
| tgt_ack | input | 1 | Target acknowledge |
| tgt_rdata | input | 64 | Target read data, valid with `tgt_ack` |

## Verification
The assertions check the target handshake on every cycle: the request holds with stable fields until the acknowledge, busy covers the whole access, and one response follows each acknowledge. They also check that each flag-setting error shows up in the flag register and on the response, and that a flag write leaves no written-one bit set. Only the bench's scenarios show that the data returned matches the target contents at the latched offset, that sink writes and unassigned reads leave all state alone, and that address bits [2:0] are ignored. The bench checks these against a reference model of the target and the local registers, using random operations mixed with directed corner cases.

// File: rtl/idxb_pkg.sv
package idxb_pkg;
  localparam int DW          = 64;
  localparam int OFF_W       = 12;
  localparam int STAT_W      = 2;
  localparam int XFER_BYTES  = 8;

  // register index map (byte address >> 3)
  localparam int IDX_OFFSET  = 0;
  localparam int IDX_WINDOW  = 1;
  localparam int IDX_FLAGS   = 2;
  localparam int N_SINK      = 2;
  localparam int SINK_IDX [N_SINK] = '{5, 6};

  // flag bit positions
  localparam int FL_UNK_BIT  = 0;
  localparam int FL_SIZE_BIT = 1;

  typedef enum logic [2:0] {
    RK_OFFSET,
    RK_WINDOW,
    RK_FLAGS,
    RK_SINK,
    RK_UNKNOWN
  } rkind_e;

  // write-one-to-clear update
  function automatic logic [STAT_W-1:0] w1c(input logic [STAT_W-1:0] cur,
                                            input logic [STAT_W-1:0] ones);
    return cur & ~ones;
  endfunction

  function automatic logic [DW-1:0] zext_off(input logic [OFF_W-1:0] o);
    return {{(DW-OFF_W){1'b0}}, o};
  endfunction

  function automatic logic [DW-1:0] zext_flags(input logic [STAT_W-1:0] f);
    return {{(DW-STAT_W){1'b0}}, f};
  endfunction
endpackage

// File: rtl/idxb_decode.sv
module idxb_decode
  import idxb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-4:0] idx,
  input  logic [3:0]    size,
  output rkind_e        kind,
  output logic          size_ok
);
  logic [31:0] idx32;
  logic [N_SINK-1:0] sink_hit;

  assign idx32   = 32'(idx);
  assign size_ok = (size == 4'(XFER_BYTES));

  for (genvar g = 0; g < N_SINK; g++) begin : g_sink
    assign sink_hit[g] = (idx32 == 32'(SINK_IDX[g]));
  end

  always_comb begin
    if (idx32 == 32'(IDX_OFFSET))      kind = RK_OFFSET;
    else if (idx32 == 32'(IDX_WINDOW)) kind = RK_WINDOW;
    else if (idx32 == 32'(IDX_FLAGS))  kind = RK_FLAGS;
    else if (|sink_hit)                kind = RK_SINK;
    else                               kind = RK_UNKNOWN;
  end
endmodule

// File: rtl/idxb_regs.sv
module idxb_regs
  import idxb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              off_we,
  input  logic [DW-1:0]     wdata,
  input  logic              flags_we,
  input  logic              set_unk,
  input  logic              set_size,
  output logic [OFF_W-1:0]  off_q,
  output logic [STAT_W-1:0] flags_q
);
  logic [STAT_W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[FL_UNK_BIT]  = set_unk;
    set_vec[FL_SIZE_BIT] = set_size;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      flags_q <= '0;
    end else begin
      if (off_we) off_q <= wdata[OFF_W-1:0];
      if (flags_we) flags_q <= w1c(flags_q, wdata[STAT_W-1:0]);
      else          flags_q <= flags_q | set_vec;
    end
  end
endmodule

// File: rtl/idxb_fwd.sv
module idxb_fwd
  import idxb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_we,
  input  logic [OFF_W-1:0] start_off,
  input  logic [DW-1:0]    start_wdata,
  output logic             tgt_req,
  output logic             tgt_we,
  output logic [OFF_W-1:0] tgt_off,
  output logic [DW-1:0]    tgt_wdata,
  input  logic             tgt_ack,
  input  logic [DW-1:0]    tgt_rdata,
  output logic             busy,
  output logic             fin,
  output logic [DW-1:0]    fin_rdata
);
  typedef enum logic {FS_IDLE, FS_WAIT} fstate_e;
  fstate_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= FS_IDLE;
      tgt_we    <= 1'b0;
      tgt_off   <= '0;
      tgt_wdata <= '0;
    end else begin
      case (st_q)
        FS_IDLE: if (start) begin
          st_q      <= FS_WAIT;
          tgt_we    <= start_we;
          tgt_off   <= start_off;
          tgt_wdata <= start_we ? start_wdata : '0;
        end
        FS_WAIT: if (tgt_ack) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign tgt_req   = (st_q == FS_WAIT);
  assign busy      = tgt_req;
  assign fin       = tgt_req & tgt_ack;
  assign fin_rdata = tgt_we ? '0 : tgt_rdata;
endmodule

// File: rtl/idxb_top.sv
module idxb_top
  import idxb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sb_req,
  input  logic             sb_we,
  input  logic [AW-1:0]    sb_addr,
  input  logic [3:0]       sb_size,
  input  logic [DW-1:0]    sb_wdata,
  output logic             sb_busy,
  output logic             sb_done,
  output logic [DW-1:0]    sb_rdata,
  output logic             sb_err,
  output logic             tgt_req,
  output logic             tgt_we,
  output logic [OFF_W-1:0] tgt_off,
  output logic [DW-1:0]    tgt_wdata,
  input  logic             tgt_ack,
  input  logic [DW-1:0]    tgt_rdata
);
  rkind_e            kind;
  logic              size_ok;
  logic [OFF_W-1:0]  off_q;
  logic [STAT_W-1:0] flags_q;
  logic              fwd_busy, fwd_fin;
  logic [DW-1:0]     fwd_rdata;
  logic [DW-1:0]     local_rd;
  logic              unused_addr_lsb;

  // named events for the checker
  logic ev_acc, ev_bad_size, ev_ok, ev_window, ev_off_wr;
  logic ev_flags_wr, ev_unk_wr, ev_local;

  assign unused_addr_lsb = ^sb_addr[2:0];

  idxb_decode #(.AW(AW)) u_dec (
    .idx     (sb_addr[AW-1:3]),
    .size    (sb_size),
    .kind    (kind),
    .size_ok (size_ok)
  );

  assign ev_acc      = sb_req & ~fwd_busy;
  assign ev_bad_size = ev_acc & ~size_ok;
  assign ev_ok       = ev_acc & size_ok;
  assign ev_window   = ev_ok & (kind == RK_WINDOW);
  assign ev_off_wr   = ev_ok & sb_we & (kind == RK_OFFSET);
  assign ev_flags_wr = ev_ok & sb_we & (kind == RK_FLAGS);
  assign ev_unk_wr   = ev_ok & sb_we & (kind == RK_UNKNOWN);
  assign ev_local    = ev_acc & ~ev_window;

  idxb_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .off_we   (ev_off_wr),
    .wdata    (sb_wdata),
    .flags_we (ev_flags_wr),
    .set_unk  (ev_unk_wr),
    .set_size (ev_bad_size),
    .off_q    (off_q),
    .flags_q  (flags_q)
  );

  idxb_fwd u_fwd (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ev_window),
    .start_we    (sb_we),
    .start_off   (off_q),
    .start_wdata (sb_wdata),
    .tgt_req     (tgt_req),
    .tgt_we      (tgt_we),
    .tgt_off     (tgt_off),
    .tgt_wdata   (tgt_wdata),
    .tgt_ack     (tgt_ack),
    .tgt_rdata   (tgt_rdata),
    .busy        (fwd_busy),
    .fin         (fwd_fin),
    .fin_rdata   (fwd_rdata)
  );

  always_comb begin
    case (kind)
      RK_OFFSET: local_rd = zext_off(off_q);
      RK_FLAGS:  local_rd = zext_flags(flags_q);
      default:   local_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_done  <= 1'b0;
      sb_rdata <= '0;
      sb_err   <= 1'b0;
    end else begin
      sb_done <= ev_local | fwd_fin;
      sb_err  <= ev_bad_size | ev_unk_wr;
      if (fwd_fin)                          sb_rdata <= fwd_rdata;
      else if (ev_local & size_ok & ~sb_we) sb_rdata <= local_rd;
      else                                  sb_rdata <= '0;
    end
  end

  assign sb_busy = fwd_busy;
endmodule

// File: rtl/idxb_checker.sv
module idxb_checker
  import idxb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tgt_req,
  input logic              tgt_ack,
  input logic              tgt_we,
  input logic [OFF_W-1:0]  tgt_off,
  input logic [DW-1:0]     tgt_wdata,
  input logic              sb_busy,
  input logic              sb_done,
  input logic              sb_err,
  input logic [DW-1:0]     sb_wdata,
  input logic              ev_bad_size,
  input logic              ev_flags_wr,
  input logic              ev_unk_wr,
  input logic [STAT_W-1:0] flags_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !tgt_req && !sb_done && flags_q == '0);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_off) && $stable(tgt_we) && $stable(tgt_wdata));

  a_r10_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> sb_busy);

  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req && tgt_ack |=> sb_done && !sb_err);

  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flags_wr |=> (flags_q & $past(sb_wdata[STAT_W-1:0])) == '0);

  a_r7_unknown_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unk_wr |=> flags_q[FL_UNK_BIT] && sb_done && sb_err);

  a_r8_size_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_size |=> flags_q[FL_SIZE_BIT] && sb_err && !tgt_req);
endmodule

bind idxb_top idxb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tgt_req     (tgt_req),
  .tgt_ack     (tgt_ack),
  .tgt_we      (tgt_we),
  .tgt_off     (tgt_off),
  .tgt_wdata   (tgt_wdata),
  .sb_busy     (sb_busy),
  .sb_done     (sb_done),
  .sb_err      (sb_err),
  .sb_wdata    (sb_wdata),
  .ev_bad_size (ev_bad_size),
  .ev_flags_wr (ev_flags_wr),
  .ev_unk_wr   (ev_unk_wr),
  .flags_q     (flags_q)
);

// File: tb/tb_idxb_top.sv
module tb_idxb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sb_req = 1'b0, sb_we = 1'b0;
  logic [15:0] sb_addr = '0;
  logic [3:0]  sb_size = 4'd8;
  logic [63:0] sb_wdata = '0;
  logic        sb_busy, sb_done, sb_err;
  logic [63:0] sb_rdata;
  logic        tgt_req, tgt_we;
  logic [11:0] tgt_off;
  logic [63:0] tgt_wdata;
  logic        tgt_ack = 1'b0;
  logic [63:0] tgt_rdata = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // target model state
  logic [63:0] mem [logic [11:0]];
  int          t_cnt = 0;
  logic [11:0] t_off;
  logic        t_we;
  logic [63:0] t_wd;
  int          t_wait = 0;

  // bench reference of the local registers
  logic [11:0] m_off = '0;
  logic [1:0]  m_flags = '0;

  idxb_top dut (.*);

  always #4 clk = ~clk;

  function automatic logic [63:0] tgt_default(input logic [11:0] o);
    return 64'hC3A5_0000_0000_0000 ^ (64'(o) * 64'h9E37_79B1) ^ {52'd0, o};
  endfunction

  function automatic logic [63:0] tgt_peek(input logic [11:0] o);
    if (mem.exists(o)) return mem[o];
    return tgt_default(o);
  endfunction

  function automatic bit is_sink(input int i);
    return i == 5 || i == 6;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (tgt_ack) tgt_ack <= 1'b0;
    else if (tgt_req) begin
      if (t_wait == 0) begin
        tgt_ack   <= 1'b1;
        tgt_rdata <= tgt_we ? 64'hDEAD_BEEF_0BAD_F00D : tgt_peek(tgt_off);
        if (tgt_we) mem[tgt_off] = tgt_wdata;
        t_cnt++; t_off = tgt_off; t_we = tgt_we; t_wd = tgt_wdata;
        t_wait = $urandom % 4;
      end else t_wait--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [15:0] a, input logic [3:0] sz,
                      input logic [63:0] wd, output logic [63:0] rd, output bit er,
                      output bit busy_first);
    int n;
    @(negedge clk);
    sb_req = 1'b1; sb_we = we; sb_addr = a; sb_size = sz; sb_wdata = wd;
    @(negedge clk);
    sb_req = 1'b0;
    busy_first = sb_busy;
    n = 0;
    while (!sb_done && n < 40) begin @(negedge clk); n++; end
    if (!sb_done) chk(1'b0, "R10 response timeout", 64'(n), 64'd40);
    rd = sb_rdata; er = sb_err;
  endtask

  // one operation checked against the bench model
  task automatic op(input bit we, input int idx, input logic [2:0] lsb,
                    input logic [3:0] sz, input logic [63:0] wd);
    logic [63:0] rd, e_rd;
    bit er, e_er, bf;
    int c0, e_acc;
    string tag;
    e_rd = '0; e_er = 1'b0; e_acc = 0;
    if (sz != 4'd8) begin
      tag = "R8 bad size"; e_er = 1'b1;
    end else if (idx == 0) begin
      tag = we ? "R2 offset write" : "R2 offset read";
      if (!we) e_rd = {52'd0, m_off};
    end else if (idx == 1) begin
      tag = we ? "R4 window write" : "R3 window read";
      e_acc = 1;
      if (!we) e_rd = tgt_peek(m_off);
    end else if (idx == 2) begin
      tag = we ? "R5 flag clear" : "R5 flag read";
      if (!we) e_rd = {62'd0, m_flags};
    end else if (is_sink(idx)) begin
      tag = "R6 sink access";
    end else begin
      tag = we ? "R7 unknown write" : "R11 unknown read";
      e_er = we;
    end
    c0 = t_cnt;
    xfer(we, 16'((idx << 3) | int'(lsb)), sz, wd, rd, er, bf);
    chk(rd == e_rd, tag, rd, e_rd);
    chk(er == e_er, tag, 64'(er), 64'(e_er));
    chk(t_cnt - c0 == e_acc, tag, 64'(t_cnt - c0), 64'(e_acc));
    if (e_acc == 1) begin
      chk(bf == 1'b1, "R10 busy during access", 64'(bf), 64'd1);
      chk(t_off == m_off && t_we == we, tag, {51'd0, t_we, t_off}, {51'd0, we, m_off});
      if (we) chk(t_wd == wd, "R4 target data", t_wd, wd);
    end
    // model update
    if (sz != 4'd8) m_flags[1] = 1'b1;
    else if (we) begin
      if (idx == 0) m_off = wd[11:0];
      else if (idx == 2) m_flags = m_flags & ~wd[1:0];
      else if (idx != 1 && !is_sink(idx)) m_flags[0] = 1'b1;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tgt_req == 1'b0 && sb_done == 1'b0 && sb_busy == 1'b0, "R1 reset outputs",
        {61'd0, tgt_req, sb_done, sb_busy}, 64'd0);
    rst_n = 1'b1;
    op(1'b0, 0, 3'd0, 4'd8, '0);            // R1 offset reads zero
    op(1'b0, 2, 3'd0, 4'd8, '0);            // R1 flags read zero
    // R2 only 12 bits kept
    op(1'b1, 0, 3'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FABC);
    op(1'b0, 0, 3'd0, 4'd8, '0);
    // R9 low address bits ignored
    op(1'b1, 0, 3'd7, 4'd8, 64'h0000_0000_0000_0123);
    op(1'b0, 0, 3'd5, 4'd8, '0);
    // R4 then R3 at same offset, R3 at untouched offset
    op(1'b1, 1, 3'd3, 4'd8, 64'h1122_3344_5566_7788);
    op(1'b0, 1, 3'd0, 4'd8, '0);
    op(1'b1, 0, 3'd0, 4'd8, 64'h0000_0000_0000_0FFF);
    op(1'b0, 1, 3'd0, 4'd8, '0);
    // R6 sink writes leave state alone
    op(1'b1, 5, 3'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    op(1'b1, 6, 3'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    op(1'b0, 6, 3'd0, 4'd8, '0);
    op(1'b0, 0, 3'd0, 4'd8, '0);
    op(1'b0, 2, 3'd0, 4'd8, '0);
    // R11 unknown read, R7 unknown write, R8 bad size
    op(1'b0, 9, 3'd0, 4'd8, '0);
    op(1'b0, 2, 3'd0, 4'd8, '0);
    op(1'b1, 3, 3'd0, 4'd8, 64'h5);
    op(1'b1, 1, 3'd0, 4'd4, 64'hAAAA);      // window write with bad size: no target access
    op(1'b0, 2, 3'd0, 4'd8, '0);
    // R5 write-one-to-clear
    op(1'b1, 2, 3'd0, 4'd8, 64'h0);
    op(1'b1, 2, 3'd0, 4'd8, 64'h1);
    op(1'b0, 2, 3'd0, 4'd8, '0);
    op(1'b1, 2, 3'd0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE);
    op(1'b0, 2, 3'd0, 4'd8, '0);
    // constrained random mix
    void'($urandom(32'h1DB5));
    for (int k = 0; k < 400; k++) begin
      int r, idx;
      logic [3:0] sz;
      r = $urandom % 16;
      if (r < 4) idx = 1;
      else if (r < 7) idx = 0;
      else if (r < 9) idx = 2;
      else if (r < 11) idx = 5 + ($urandom % 2);
      else idx = $urandom % 64;
      sz = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'd8;
      op(1'($urandom), idx, 3'($urandom), sz, {$urandom, $urandom});
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule